// File: doc/BRIEF.md
# Regulator Voltage Code Controller

This block keeps the output-voltage codes for three supply rails of a power manager. One is a switching rail. Its default code comes from a select pin that picks one of two parameter values. The other two are linear rails. Both of their defaults come from a two-bit strap bus. The defaults are captured on the first clock after reset. After that, a plain register-write port can change any of the three codes. That port would usually be driven by a serial-bus slave, and a combinational read port returns the stored codes.

The switching rail gets extra care. A hot reset forces its code back to the latched default, and so does a low backup supply, undervoltage lockout or an active power-on reset. These four conditions are asynchronous, so they pass through a synchronizer before they are used. The code also goes back to its default while both the switching rail and its companion rail are disabled. When the companion rail is switched off, the code is rewritten to a fixed pattern: the top bit is set, the bottom bit is cleared and the bits between them are kept. The linear-rail codes are never touched by any of these events. The asynchronous reset input stands for loss of the core supply, and it clears everything.

Top module: `vreg_code_ctrl`

## Requirements
- R1: On the first clock edge after reset is released, the switching code loads SW_DEF1 when `sw_def_sel_i` is 1 and SW_DEF0 when it is 0 (defaults 5'h16 and 5'h0C). The linear codes load in the same edge.
- R2: The strap bus `lin_strap_i` (bit 1 is the high-order pin) sets the linear codes as follows (rail 1 / rail 2):
  - 00 gives 4'd1 / 4'd2 (1.1 V / 1.3 V).
  - 01 gives 4'd3 / 4'd2 (1.5 V / 1.3 V).
  - 10 gives 4'd9 / 4'd10 (2.6 V / 2.8 V).
  - 11 gives 4'd12 / 4'd13 (3.15 V / 3.3 V).
- R3: The strap bus and the select pin are sampled only on that first edge. Later changes to them have no effect on any code, including the default that a later restore uses.
- R4: A write to address 0x03 (switching code), 0x05 (rail 1) or 0x06 (rail 2) updates that code at the clock edge. A read of those addresses returns the code, zero-extended to 8 bits.
- R5: A read of any other address returns 0xFF. A write to any other address changes no code.
- R6: A hot-reset assertion restores the switching code to its latched default on the third clock edge after the input rises. The first two edges are synchronizer stages. The linear codes keep their values.
- R7: Backup-supply-low, undervoltage lockout and power-on reset each restore the switching code to its default with the same three-edge latency as R6.
- R8: While `sw_en_i` and `comp_en_i` are both 0, the switching code is held at its default and writes to it are ignored.
- R9: On the edge where `comp_en_i` is first seen low after being high, the switching code becomes {1, bits 3..1 unchanged, 0}, provided that `sw_en_i` is 1 and no restore condition is active.
- R10: When a restore condition and a switching-code write occur in the same cycle, the restore wins. A linear-code write in that cycle still takes effect.
- R11: A write whose data has any bit set above the target field is discarded. The switching field is bits 4..0 and the linear fields are bits 3..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (core supply lost) |
| sw_def_sel_i | input | 1 | Switching-rail default select pin |
| lin_strap_i | input | 2 | Linear-rail default strap pins |
| hot_rst_i | input | 1 | Hot reset, asynchronous |
| bkup_low_i | input | 1 | Backup supply below threshold, asynchronous |
| uvlo_i | input | 1 | Undervoltage lockout active, asynchronous |
| por_i | input | 1 | Power-on reset output active, asynchronous |
| sw_en_i | input | 1 | Switching rail enabled |
| comp_en_i | input | 1 | Companion rail enabled |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| sw_code_o | output | 5 | Switching-rail voltage code |
| lin1_code_o | output | 4 | Linear rail 1 voltage code |
| lin2_code_o | output | 4 | Linear rail 2 voltage code |

## Verification
The bench uses the default parameters: a 5-bit switching code, a two-stage synchronizer and 8-bit data. The two-stage synchronizer makes the restore latency exactly three edges. The bench can therefore check the code as unchanged after two edges and as restored after the third. An 8-bit data word with 5-bit and 4-bit fields leaves spare upper bits, which is what makes the discarded-write case of R11 reachable. All four strap values are driven with both select settings across repeated resets.

// File: rtl/vreg_code_pkg.sv
package vreg_code_pkg;

    localparam int LIN_W    = 4;
    localparam int COND_N   = 4;
    localparam int COND_HOT = 0;
    localparam int COND_BKP = 1;
    localparam int COND_UV  = 2;
    localparam int COND_POR = 3;

    // rail-1 default code for each strap value
    function automatic logic [LIN_W-1:0] lin1_default(input logic [1:0] strap);
        case (strap)
            2'b00:   return LIN_W'(1);
            2'b01:   return LIN_W'(3);
            2'b10:   return LIN_W'(9);
            default: return LIN_W'(12);
        endcase
    endfunction

    // rail-2 default code for each strap value
    function automatic logic [LIN_W-1:0] lin2_default(input logic [1:0] strap);
        case (strap)
            2'b00, 2'b01: return LIN_W'(2);
            2'b10:        return LIN_W'(10);
            default:      return LIN_W'(13);
        endcase
    endfunction

endpackage

// File: rtl/vreg_cond_sync.sv
module vreg_cond_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/vreg_lin_rails.sv
module vreg_lin_rails
    import vreg_code_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic [1:0]       strap_i,
    input  logic             wr1_i,
    input  logic             wr2_i,
    input  logic [LIN_W-1:0] wr_data_i,
    output logic [LIN_W-1:0] lin1_o,
    output logic [LIN_W-1:0] lin2_o
);

    typedef struct packed {
        logic [LIN_W-1:0] lin1;
        logic [LIN_W-1:0] lin2;
    } lin_state_t;

    lin_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (init_i) begin
            st_d.lin1 = lin1_default(strap_i);
            st_d.lin2 = lin2_default(strap_i);
        end else begin
            if (wr1_i) st_d.lin1 = wr_data_i;
            if (wr2_i) st_d.lin2 = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lin1_o = st_q.lin1;
    assign lin2_o = st_q.lin2;

    // R3: after the power-up load, straps never move a linear code
    assert_strap_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !wr1_i && !wr2_i) |=> ($stable(lin1_o) && $stable(lin2_o)));

endmodule

// File: rtl/vreg_sw_rail.sv
module vreg_sw_rail #(
    parameter int              SW_W    = 5,
    parameter logic [SW_W-1:0] SW_DEF0 = 5'h0C,
    parameter logic [SW_W-1:0] SW_DEF1 = 5'h16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init_i,
    input  logic            def_sel_i,
    input  logic            restore_i,
    input  logic            sw_en_i,
    input  logic            comp_en_i,
    input  logic            wr_i,
    input  logic [SW_W-1:0] wr_data_i,
    output logic [SW_W-1:0] code_o
);

    typedef struct packed {
        logic [SW_W-1:0] code;
        logic [SW_W-1:0] def;
        logic            comp_en;
    } sw_state_t;

    sw_state_t st_d, st_q;
    logic      both_off;
    logic      comp_fall;

    always_comb begin
        st_d      = st_q;
        both_off  = !sw_en_i && !comp_en_i;
        comp_fall = st_q.comp_en && !comp_en_i;
        st_d.comp_en = comp_en_i;
        if (init_i) begin
            st_d.def  = def_sel_i ? SW_DEF1 : SW_DEF0;
            st_d.code = def_sel_i ? SW_DEF1 : SW_DEF0;
        end else if (restore_i || both_off) begin
            st_d.code = st_q.def;
        end else if (comp_fall) begin
            st_d.code = {1'b1, st_q.code[SW_W-2:1], 1'b0};
        end else if (wr_i) begin
            st_d.code = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_o = st_q.code;

    // R6 / R7: a synchronized restore condition yields the latched default
    assert_restore_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && restore_i) |=> (code_o == st_q.def));

    // R8: both rails off keeps the default regardless of writes
    assert_both_off_default_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !sw_en_i && !comp_en_i) |=> (code_o == st_q.def));

    // R9: companion turn-off pattern
    assert_comp_off_pattern_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !restore_i && sw_en_i && st_q.comp_en && !comp_en_i)
        |=> (code_o[SW_W-1] && !code_o[0] && (code_o[SW_W-2:1] == $past(code_o[SW_W-2:1]))));

    // R10: a restore in the same cycle beats a write
    assert_restore_beats_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && restore_i && wr_i) |=> (code_o == st_q.def));

endmodule

// File: rtl/vreg_code_ctrl.sv
module vreg_code_ctrl
    import vreg_code_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 8,
    parameter int                SW_W        = 5,
    parameter int                SYNC_STAGES = 2,
    parameter logic [SW_W-1:0]   SW_DEF0     = 5'h0C,
    parameter logic [SW_W-1:0]   SW_DEF1     = 5'h16,
    parameter logic [ADDR_W-1:0] ADDR_SW     = 8'h03,
    parameter logic [ADDR_W-1:0] ADDR_LIN1   = 8'h05,
    parameter logic [ADDR_W-1:0] ADDR_LIN2   = 8'h06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_def_sel_i,
    input  logic [1:0]        lin_strap_i,
    input  logic              hot_rst_i,
    input  logic              bkup_low_i,
    input  logic              uvlo_i,
    input  logic              por_i,
    input  logic              sw_en_i,
    input  logic              comp_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [SW_W-1:0]   sw_code_o,
    output logic [LIN_W-1:0]  lin1_code_o,
    output logic [LIN_W-1:0]  lin2_code_o
);

    localparam int SW_PAD  = DATA_W - SW_W;
    localparam int LIN_PAD = DATA_W - LIN_W;

    typedef struct packed {
        logic loaded;
    } top_state_t;

    top_state_t        st_d, st_q;
    logic [COND_N-1:0] cond_async, cond_sync;
    logic              restore;
    logic              sw_wr, lin1_wr, lin2_wr;
    logic              sw_fit, lin_fit;

    always_comb begin
        st_d        = st_q;
        st_d.loaded = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cond_async[COND_HOT] = hot_rst_i;
    assign cond_async[COND_BKP] = bkup_low_i;
    assign cond_async[COND_UV]  = uvlo_i;
    assign cond_async[COND_POR] = por_i;

    vreg_cond_sync #(
        .WIDTH  (COND_N),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cond_async),
        .sync_o  (cond_sync)
    );

    assign restore = |cond_sync;
    assign sw_fit  = ~|wr_data_i[DATA_W-1:SW_W];
    assign lin_fit = ~|wr_data_i[DATA_W-1:LIN_W];
    assign sw_wr   = wr_en_i && (wr_addr_i == ADDR_SW)   && sw_fit;
    assign lin1_wr = wr_en_i && (wr_addr_i == ADDR_LIN1) && lin_fit;
    assign lin2_wr = wr_en_i && (wr_addr_i == ADDR_LIN2) && lin_fit;

    vreg_sw_rail #(
        .SW_W    (SW_W),
        .SW_DEF0 (SW_DEF0),
        .SW_DEF1 (SW_DEF1)
    ) u_sw (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_i    (!st_q.loaded),
        .def_sel_i (sw_def_sel_i),
        .restore_i (restore),
        .sw_en_i   (sw_en_i),
        .comp_en_i (comp_en_i),
        .wr_i      (sw_wr),
        .wr_data_i (wr_data_i[SW_W-1:0]),
        .code_o    (sw_code_o)
    );

    vreg_lin_rails u_lin (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_i    (!st_q.loaded),
        .strap_i   (lin_strap_i),
        .wr1_i     (lin1_wr),
        .wr2_i     (lin2_wr),
        .wr_data_i (wr_data_i[LIN_W-1:0]),
        .lin1_o    (lin1_code_o),
        .lin2_o    (lin2_code_o)
    );

    always_comb begin
        rd_data_o = '1;
        if (rd_addr_i == ADDR_SW)   rd_data_o = {{SW_PAD{1'b0}}, sw_code_o};
        if (rd_addr_i == ADDR_LIN1) rd_data_o = {{LIN_PAD{1'b0}}, lin1_code_o};
        if (rd_addr_i == ADDR_LIN2) rd_data_o = {{LIN_PAD{1'b0}}, lin2_code_o};
    end

    // R6: hot reset leaves the linear codes alone
    assert_hot_keeps_lin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.loaded && cond_sync[COND_HOT] && !lin1_wr && !lin2_wr)
        |=> ($stable(lin1_code_o) && $stable(lin2_code_o)));

    // R11: an oversized write never reaches the switching code
    assert_wide_write_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.loaded && !restore && sw_en_i && comp_en_i && wr_en_i && !sw_fit
         && !(wr_en_i && (wr_addr_i != ADDR_SW)))
        |=> $stable(sw_code_o));

endmodule

// File: tb/vreg_code_ctrl_tb.sv
module vreg_code_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_def_sel = 1'b0;
    logic [1:0] lin_strap = 2'b00;
    logic       hot_rst = 1'b0, bkup_low = 1'b0, uvlo = 1'b0, por = 1'b0;
    logic       sw_en = 1'b1, comp_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00, wr_data = 8'h00, rd_addr = 8'h00;
    logic [7:0] rd_data;
    logic [4:0] sw_code;
    logic [3:0] lin1_code, lin2_code;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vreg_code_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_def_sel_i (sw_def_sel),
        .lin_strap_i  (lin_strap),
        .hot_rst_i    (hot_rst),
        .bkup_low_i   (bkup_low),
        .uvlo_i       (uvlo),
        .por_i        (por),
        .sw_en_i      (sw_en),
        .comp_en_i    (comp_en),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .rd_addr_i    (rd_addr),
        .rd_data_o    (rd_data),
        .sw_code_o    (sw_code),
        .lin1_code_o  (lin1_code),
        .lin2_code_o  (lin2_code)
    );

    function automatic logic [7:0] exp_lin1(input logic [1:0] s);
        case (s)
            2'b00: return 8'd1;
            2'b01: return 8'd3;
            2'b10: return 8'd9;
            default: return 8'd12;
        endcase
    endfunction

    function automatic logic [7:0] exp_lin2(input logic [1:0] s);
        case (s)
            2'b00: return 8'd2;
            2'b01: return 8'd2;
            2'b10: return 8'd10;
            default: return 8'd13;
        endcase
    endfunction

    function automatic logic [7:0] exp_sw(input logic sel);
        return sel ? 8'h16 : 8'h0C;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] addr, input logic [7:0] exp);
        rd_addr = addr;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic wr(input logic [7:0] addr, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset(input logic [1:0] strap, input logic sel);
        @(negedge clk);
        rst_n = 1'b0;
        lin_strap = strap; sw_def_sel = sel;
        hot_rst = 0; bkup_low = 0; uvlo = 0; por = 0;
        sw_en = 1; comp_en = 1; wr_en = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_cond(input int idx, input logic v);
        case (idx)
            0: hot_rst = v;
            1: bkup_low = v;
            2: uvlo = v;
            default: por = v;
        endcase
    endtask

    task automatic t_defaults();
        for (int s = 0; s < 4; s++) begin
            for (int sel = 0; sel < 2; sel++) begin
                do_reset(2'(s), 1'(sel));
                chk("R1 sw default", {3'b0, sw_code}, exp_sw(1'(sel)));
                chk("R2 lin1 strap", {4'b0, lin1_code}, exp_lin1(2'(s)));
                chk("R2 lin2 strap", {4'b0, lin2_code}, exp_lin2(2'(s)));
            end
        end
    endtask

    task automatic t_strap_latched();
        do_reset(2'b10, 1'b1);
        lin_strap = 2'b01; sw_def_sel = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 lin1 after strap change", {4'b0, lin1_code}, 8'd9);
        chk("R3 lin2 after strap change", {4'b0, lin2_code}, 8'd10);
        wr(8'h03, 8'h01);
        hot_rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 restore uses latched select", {3'b0, sw_code}, 8'h16);
        hot_rst = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_write_read();
        do_reset(2'b00, 1'b0);
        wr(8'h03, 8'h1B);
        wr(8'h05, 8'h07);
        wr(8'h06, 8'h0E);
        chk("R4 sw code port", {3'b0, sw_code}, 8'h1B);
        rd_chk("R4 read sw", 8'h03, 8'h1B);
        rd_chk("R4 read lin1", 8'h05, 8'h07);
        rd_chk("R4 read lin2", 8'h06, 8'h0E);
    endtask

    task automatic t_unmapped();
        rd_chk("R5 unmapped read 0x04", 8'h04, 8'hFF);
        rd_chk("R5 unmapped read 0x00", 8'h00, 8'hFF);
        wr(8'h04, 8'h02);
        wr(8'h83, 8'h02);
        chk("R5 sw after unmapped write", {3'b0, sw_code}, 8'h1B);
        chk("R5 lin1 after unmapped write", {4'b0, lin1_code}, 8'h07);
        chk("R5 lin2 after unmapped write", {4'b0, lin2_code}, 8'h0E);
    endtask

    task automatic t_wide_data();
        wr(8'h03, 8'h25);
        chk("R11 sw oversized write dropped", {3'b0, sw_code}, 8'h1B);
        wr(8'h05, 8'h1A);
        chk("R11 lin1 oversized write dropped", {4'b0, lin1_code}, 8'h07);
        wr(8'h03, 8'h1F);
        chk("R11 sw full-width write kept", {3'b0, sw_code}, 8'h1F);
    endtask

    task automatic cond_restore(input int idx, input string tag);
        wr(8'h03, 8'h05);
        set_cond(idx, 1'b1);
        repeat (2) @(negedge clk);
        chk({tag, " still old after 2 edges"}, {3'b0, sw_code}, 8'h05);
        @(negedge clk);
        chk({tag, " default on third edge"}, {3'b0, sw_code}, 8'h0C);
        set_cond(idx, 1'b0);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_hot_reset();
        do_reset(2'b11, 1'b0);
        wr(8'h05, 8'h04);
        wr(8'h06, 8'h08);
        cond_restore(0, "R6 hot");
        chk("R6 lin1 kept", {4'b0, lin1_code}, 8'h04);
        chk("R6 lin2 kept", {4'b0, lin2_code}, 8'h08);
    endtask

    task automatic t_other_conds();
        cond_restore(1, "R7 backup low");
        cond_restore(2, "R7 uvlo");
        cond_restore(3, "R7 por");
    endtask

    task automatic t_both_off();
        wr(8'h03, 8'h11);
        sw_en = 1'b0; comp_en = 1'b0;
        @(negedge clk);
        chk("R8 default when both off", {3'b0, sw_code}, 8'h0C);
        wr(8'h03, 8'h13);
        chk("R8 write ignored when both off", {3'b0, sw_code}, 8'h0C);
        sw_en = 1'b1;
        @(negedge clk);
        comp_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_comp_off();
        wr(8'h03, 8'h0B);
        comp_en = 1'b0;
        @(negedge clk);
        chk("R9 comp off 01011", {3'b0, sw_code}, 8'h1A);
        @(negedge clk);
        chk("R9 pattern held", {3'b0, sw_code}, 8'h1A);
        comp_en = 1'b1;
        wr(8'h03, 8'h15);
        comp_en = 1'b0;
        @(negedge clk);
        chk("R9 comp off 10101", {3'b0, sw_code}, 8'h14);
        comp_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_collide();
        bkup_low = 1'b1;
        repeat (3) @(negedge clk);
        wr(8'h03, 8'h07);
        chk("R10 restore beats sw write", {3'b0, sw_code}, 8'h0C);
        wr(8'h05, 8'h06);
        chk("R10 lin write during restore", {4'b0, lin1_code}, 8'h06);
        bkup_low = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_defaults();
        t_strap_latched();
        t_write_read();
        t_unmapped();
        t_wide_data();
        t_hot_reset();
        t_other_conds();
        t_both_off();
        t_comp_off();
        t_collide();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule